// File: doc/BRIEF.md
# Quadrant Motion-Energy Detector

This block watches a live video stream for movement. Each clock it receives one pixel of the current picture and the pixel at the same position one frame earlier. The earlier pixel arrives already aligned by an external frame delay. Each beat also carries its column and row, a qualifier and a flag that marks the last pixel of a field. For every qualified beat the block forms the magnitude of the change between the two pixels and sends it out as a difference-image stream.

The picture is divided into four quadrants at half the programmed width and half the programmed field height. Each quadrant adds its changes into its own running total. When the last pixel of a field has been counted, all four totals are compared at once with a threshold that can be rewritten at any time. The result is one activity bit per quadrant. The activity bits and the four totals are held while the next field, which may be the other interlaced half-frame, is gathered from zero.

Top module: `qsad_motion`

## Requirements
- R1: For a beat with `in_valid` high, `diff_valid` is high one cycle later and `diff_pix` carries |`cur_pix` − `ref_pix`| as a 9-bit value with its top bit zero.
- R2: A qualified pixel is routed to quadrant index {y ≥ `cfg_height`/2, x ≥ `cfg_width`/2} (halves rounded down). Index 0 is upper-left, 1 upper-right, 2 lower-left and 3 lower-right. Bit q of `motion` and slice q of `sad_totals` belong to index q.
- R3: Each quadrant sums the differences of its qualified pixels in a 27-bit accumulator, and all four sum in the same cycle without stalls.
- R4: A qualified beat with `in_eof` high closes the field, and its own difference is included. Two cycles after that beat is sampled, `field_done` is high for one cycle and `sad_totals` shows the four field sums.
- R5: At a field close, `motion` bit q is 1 exactly when sum q is strictly greater than the threshold. A sum equal to the threshold gives 0.
- R6: The threshold used is the value of `cfg_thresh` at the clock edge that closes the field. Changes made earlier in the field have no effect on that comparison.
- R7: After a close, every quadrant starts the next field from zero, so each field (half-frame) is judged only on its own pixels.
- R8: `motion` and `sad_totals` change only in the cycle where `field_done` is high and otherwise hold their values.
- R9: A beat with `in_valid` low is ignored entirely, including its `in_eof`. `diff_valid` is low one cycle later, `diff_pix` reads 0, and no total and no flag changes.
- R10: A synchronous active-high `rst` clears the accumulators, `motion`, `sad_totals`, `field_done`, `diff_valid` and `diff_pix`. An unfinished field is discarded.
- R11: `cfg_width` and `cfg_height` are runtime inputs, and the quadrant boundaries follow them, including odd values.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Beat qualifier |
| in_eof | input | 1 | Last pixel of the field |
| in_x | input | 10 | Pixel column |
| in_y | input | 10 | Pixel row within the field |
| cur_pix | input | 8 | Current picture pixel |
| ref_pix | input | 8 | Co-located pixel of the previous frame |
| cfg_width | input | 10 | Active width in pixels |
| cfg_height | input | 10 | Field height in lines |
| cfg_thresh | input | 27 | Motion threshold |
| diff_valid | output | 1 | Difference stream qualifier |
| diff_pix | output | 9 | Absolute difference stream |
| field_done | output | 1 | One-cycle pulse when flags and totals update |
| motion | output | 4 | Per-quadrant activity flag |
| sad_totals | output | 108 | Four 27-bit held field sums, quadrant q at bits [27q+26:27q] |

## Verification
The bench sets a quadrant's sum exactly equal to the threshold, and then one above it. A design that compared with "greater or equal" would flag the quadrant whose sum equals the threshold. The threshold is also raised just before the closing pixel, which exposes a design that latches it early. Qualifier-low beats carry a raised end-of-field flag and wild coordinates, so a design that forgets to qualify either would close fields early or corrupt a total. Further cases are back-to-back fields, an odd width and height, and a reset in the middle of a field. These reveal totals that leak across fields, boundaries rounded the wrong way, and partial sums that survive reset.

// File: rtl/qsad_pkg.sv
`timescale 1ns/1ps
package qsad_pkg;
    localparam int PIX_W   = 8;
    localparam int DIFF_W  = PIX_W + 1;
    localparam int ACC_W   = 27;
    localparam int COORD_W = 10;
    localparam int NQ      = 4;
    localparam int QSEL_W  = $clog2(NQ);

    typedef struct packed {
        logic              valid;
        logic              eof;
        logic [QSEL_W-1:0] quad;
        logic [DIFF_W-1:0] diff;
    } beat_t;

    function automatic logic [DIFF_W-1:0] abs_diff(input logic [PIX_W-1:0] a,
                                                   input logic [PIX_W-1:0] b);
        logic [PIX_W-1:0] m;
        m = (a >= b) ? (a - b) : (b - a);
        return {1'b0, m};
    endfunction

    function automatic logic [QSEL_W-1:0] quad_of(input logic [COORD_W-1:0] x,
                                                  input logic [COORD_W-1:0] y,
                                                  input logic [COORD_W-1:0] w,
                                                  input logic [COORD_W-1:0] h);
        logic right, lower;
        right = (x >= (w >> 1));
        lower = (y >= (h >> 1));
        return {lower, right};
    endfunction
endpackage

// File: rtl/qsad_front.sv
`timescale 1ns/1ps
module qsad_front
    import qsad_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic               in_eof,
    input  logic [COORD_W-1:0] in_x,
    input  logic [COORD_W-1:0] in_y,
    input  logic [PIX_W-1:0]   cur_pix,
    input  logic [PIX_W-1:0]   ref_pix,
    input  logic [COORD_W-1:0] cfg_width,
    input  logic [COORD_W-1:0] cfg_height,
    output beat_t              beat
);
    // Registered stage: difference magnitude and quadrant index per beat.
    always_ff @(posedge clk) begin
        if (rst) begin
            beat <= '0;
        end else begin
            beat.valid <= in_valid;
            beat.eof   <= in_valid & in_eof;
            beat.quad  <= quad_of(in_x, in_y, cfg_width, cfg_height);
            beat.diff  <= in_valid ? abs_diff(cur_pix, ref_pix) : '0;
        end
    end
endmodule

// File: rtl/qsad_lane.sv
`timescale 1ns/1ps
module qsad_lane #(
    parameter int DW = 9,
    parameter int AW = 27
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          add_en,
    input  logic          close,
    input  logic [DW-1:0] diff,
    input  logic [AW-1:0] thresh,
    output logic          active,
    output logic [AW-1:0] total
);
    localparam int PAD = AW - DW;

    logic [AW-1:0] acc;
    logic [AW-1:0] sum_now;

    always_comb begin
        sum_now = acc + (add_en ? {{PAD{1'b0}}, diff} : '0);
    end

    // On a close the final sum (closing pixel included) is latched and compared,
    // and the running total restarts from zero for the next field.
    always_ff @(posedge clk) begin
        if (rst) begin
            acc    <= '0;
            total  <= '0;
            active <= 1'b0;
        end else if (close) begin
            acc    <= '0;
            total  <= sum_now;
            active <= (sum_now > thresh);
        end else begin
            acc    <= sum_now;
        end
    end
endmodule

// File: rtl/qsad_motion.sv
`timescale 1ns/1ps
module qsad_motion
    import qsad_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic                in_eof,
    input  logic [COORD_W-1:0]  in_x,
    input  logic [COORD_W-1:0]  in_y,
    input  logic [PIX_W-1:0]    cur_pix,
    input  logic [PIX_W-1:0]    ref_pix,
    input  logic [COORD_W-1:0]  cfg_width,
    input  logic [COORD_W-1:0]  cfg_height,
    input  logic [ACC_W-1:0]    cfg_thresh,
    output logic                diff_valid,
    output logic [DIFF_W-1:0]   diff_pix,
    output logic                field_done,
    output logic [NQ-1:0]       motion,
    output logic [NQ*ACC_W-1:0] sad_totals
);
    beat_t beat;
    logic  close;

    qsad_front u_front (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_eof     (in_eof),
        .in_x       (in_x),
        .in_y       (in_y),
        .cur_pix    (cur_pix),
        .ref_pix    (ref_pix),
        .cfg_width  (cfg_width),
        .cfg_height (cfg_height),
        .beat       (beat)
    );

    assign close      = beat.valid & beat.eof;
    assign diff_valid = beat.valid;
    assign diff_pix   = beat.diff;

    for (genvar g = 0; g < NQ; g++) begin : g_lane
        logic hit;
        assign hit = beat.valid && (beat.quad == QSEL_W'(g));
        qsad_lane #(.DW(DIFF_W), .AW(ACC_W)) u_lane (
            .clk    (clk),
            .rst    (rst),
            .add_en (hit),
            .close  (close),
            .diff   (beat.diff),
            .thresh (cfg_thresh),
            .active (motion[g]),
            .total  (sad_totals[g*ACC_W +: ACC_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) field_done <= 1'b0;
        else     field_done <= close;
    end
endmodule

// File: rtl/qsad_motion_chk.sv
`timescale 1ns/1ps
module qsad_motion_chk
    import qsad_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic                in_eof,
    input logic [PIX_W-1:0]    cur_pix,
    input logic [PIX_W-1:0]    ref_pix,
    input logic [ACC_W-1:0]    cfg_thresh,
    input logic                diff_valid,
    input logic [DIFF_W-1:0]   diff_pix,
    input logic                field_done,
    input logic [NQ-1:0]       motion,
    input logic [NQ*ACC_W-1:0] sad_totals
);
    p_diff_follow_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> diff_valid && diff_pix[DIFF_W-1] == 1'b0);

    p_diff_mag_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (int'(diff_pix) == ((int'($past(cur_pix)) >= int'($past(ref_pix)))
                      ? int'($past(cur_pix)) - int'($past(ref_pix))
                      : int'($past(ref_pix)) - int'($past(cur_pix)))));

    p_idle_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !diff_valid && diff_pix == '0);

    p_close_latency_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_eof) |-> ##2 field_done);

    p_done_cause_r4: assert property (@(posedge clk) disable iff (rst)
        field_done |-> $past(in_valid && in_eof, 2));

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !field_done |-> $stable(motion) && $stable(sad_totals));

    for (genvar g = 0; g < NQ; g++) begin : g_cmp
        p_strict_cmp_r5: assert property (@(posedge clk) disable iff (rst)
            field_done |-> motion[g] == (sad_totals[g*ACC_W +: ACC_W] > $past(cfg_thresh)));
    end

    p_reset_clear_r10: assert property (@(posedge clk)
        rst |=> motion == '0 && sad_totals == '0 && !field_done && !diff_valid);
endmodule

bind qsad_motion qsad_motion_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_eof     (in_eof),
    .cur_pix    (cur_pix),
    .ref_pix    (ref_pix),
    .cfg_thresh (cfg_thresh),
    .diff_valid (diff_valid),
    .diff_pix   (diff_pix),
    .field_done (field_done),
    .motion     (motion),
    .sad_totals (sad_totals)
);

// File: tb/qsad_motion_test.sv
`timescale 1ns/1ps
module qsad_motion_test;
    import qsad_pkg::*;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                in_valid = 1'b0;
    logic                in_eof = 1'b0;
    logic [COORD_W-1:0]  in_x = '0;
    logic [COORD_W-1:0]  in_y = '0;
    logic [PIX_W-1:0]    cur_pix = '0;
    logic [PIX_W-1:0]    ref_pix = '0;
    logic [COORD_W-1:0]  cfg_width = 10'd8;
    logic [COORD_W-1:0]  cfg_height = 10'd8;
    logic [ACC_W-1:0]    cfg_thresh = '0;
    logic                diff_valid;
    logic [DIFF_W-1:0]   diff_pix;
    logic                field_done;
    logic [NQ-1:0]       motion;
    logic [NQ*ACC_W-1:0] sad_totals;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference model state
    longint m_acc [4];
    longint m_hold[4];
    bit     m_flag[4];
    bit     p_v, p_e;
    int     p_q, p_d;
    bit     e_fd;

    always #2.5 clk = ~clk;

    qsad_motion uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_eof(in_eof),
        .in_x(in_x), .in_y(in_y), .cur_pix(cur_pix), .ref_pix(ref_pix),
        .cfg_width(cfg_width), .cfg_height(cfg_height), .cfg_thresh(cfg_thresh),
        .diff_valid(diff_valid), .diff_pix(diff_pix), .field_done(field_done),
        .motion(motion), .sad_totals(sad_totals)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int q = 0; q < 4; q++) begin
            m_acc[q] = 0; m_hold[q] = 0; m_flag[q] = 0;
        end
        p_v = 0; p_e = 0; p_q = 0; p_d = 0; e_fd = 0;
    endtask

    task automatic compare_all(input string tag);
        check(diff_valid == p_v, tag, "diff_valid", diff_valid, p_v);
        check(int'(diff_pix) == p_d, tag, "diff_pix", diff_pix, p_d);
        check(field_done == e_fd, tag, "field_done", field_done, e_fd);
        for (int q = 0; q < 4; q++) begin
            check(motion[q] == m_flag[q], tag, $sformatf("motion[%0d]", q), motion[q], m_flag[q]);
            check(longint'(sad_totals[q*ACC_W +: ACC_W]) == m_hold[q], tag,
                  $sformatf("total[%0d]", q), sad_totals[q*ACC_W +: ACC_W], m_hold[q]);
        end
    endtask

    // One clock: drive at negedge, model the edge, compare 1 ns after it.
    task automatic cycle(input bit v, input bit e, input int x, input int y,
                         input int c, input int r, input string tag);
        int q, d;
        @(negedge clk);
        in_valid = v; in_eof = e;
        in_x = COORD_W'(x); in_y = COORD_W'(y);
        cur_pix = PIX_W'(c); ref_pix = PIX_W'(r);
        @(posedge clk);
        if (p_v) m_acc[p_q] += p_d;
        e_fd = p_v && p_e;
        if (e_fd) begin
            for (int k = 0; k < 4; k++) begin
                m_hold[k] = m_acc[k] % (longint'(1) << ACC_W);
                m_flag[k] = (m_hold[k] > longint'(cfg_thresh));
                m_acc[k]  = 0;
            end
        end
        q = ((y >= int'(cfg_height) / 2) ? 2 : 0) + ((x >= int'(cfg_width) / 2) ? 1 : 0);
        d = (c >= r) ? c - r : r - c;
        p_v = v; p_e = v && e; p_q = q; p_d = v ? d : 0;
        #1;
        compare_all(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cycle(0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic field(input int w, input int h, input int seed, input string tag);
        for (int y = 0; y < h; y++) begin
            for (int x = 0; x < w; x++) begin
                int c, r;
                c = (x * 29 + y * 13 + seed * 7) % 256;
                r = (x * 5 + y * 31 + seed * 3) % 256;
                if ((x + y + seed) % 5 == 0) begin c = 255; r = 0; end
                if ((x + y + seed) % 7 == 0) begin c = 0; r = 255; end
                cycle(1, (x == w - 1) && (y == h - 1), x, y, c, r, tag);
            end
        end
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst = 1'b1;
        in_valid = 0; in_eof = 0;
        @(posedge clk); @(posedge clk);
        #1;
        model_clear();
        compare_all(tag);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        model_clear();
        // R10: reset state
        do_reset("R10");

        // R1 R2 R3 R4: full field, several pixel patterns
        cfg_width = 10'd8; cfg_height = 10'd8; cfg_thresh = 27'd1000;
        field(8, 8, 1, "R1");
        idle(2, "R4");
        // R7: following field gathered from zero
        field(8, 8, 4, "R7");
        idle(1, "R7");
        // R8: holds while idle
        idle(5, "R8");

        // R5: exact threshold boundary, 4x4 field
        cfg_width = 10'd4; cfg_height = 10'd4; cfg_thresh = 27'd100;
        cycle(1, 0, 0, 0, 100, 0, "R5");   // quadrant 0: 100
        cycle(1, 0, 2, 0, 0, 101, "R5");   // quadrant 1: 101
        cycle(1, 0, 0, 3, 40, 40, "R5");   // quadrant 2: 0
        cycle(1, 1, 3, 3, 7, 7, "R5");     // quadrant 3: 0, closes
        idle(1, "R5");
        check(motion == 4'b0010, "R5", "equal-vs-above flags", motion, 4'b0010);
        check(sad_totals[0 +: ACC_W] == 27'd100, "R5", "total q0", sad_totals[0 +: ACC_W], 100);

        // R6: threshold low during field, raised just before close edge
        cfg_thresh = 27'd0;
        cycle(1, 0, 1, 1, 200, 0, "R6");
        cycle(1, 0, 3, 1, 200, 0, "R6");
        cycle(1, 1, 3, 3, 200, 0, "R6");
        cfg_thresh = 27'd5000;
        idle(1, "R6");
        check(motion == 4'b0000, "R6", "flags with raised threshold", motion, 0);

        // R9: unqualified beats with eof raised and odd coordinates
        cycle(1, 0, 0, 0, 255, 0, "R9");
        for (int i = 0; i < 6; i++) cycle(0, 1, 900 - i, 3 * i, 255, 0, "R9");
        check(field_done == 1'b0, "R9", "no close from invalid eof", field_done, 0);
        cfg_thresh = 27'd254;
        cycle(1, 1, 1, 1, 0, 0, "R9");
        idle(1, "R9");
        check(motion == 4'b0001, "R9", "only qualified pixel counted", motion, 1);
        check(sad_totals[0 +: ACC_W] == 27'd255, "R9", "total q0", sad_totals[0 +: ACC_W], 255);

        // R11: odd dimensions move the boundaries
        cfg_width = 10'd7; cfg_height = 10'd5; cfg_thresh = 27'd600;
        field(7, 5, 2, "R11");
        idle(1, "R11");
        cfg_width = 10'd12; cfg_height = 10'd6;
        field(12, 6, 3, "R11");
        idle(2, "R11");

        // R10: reset in the middle of a field discards it
        cfg_width = 10'd8; cfg_height = 10'd8;
        for (int i = 0; i < 20; i++) cycle(1, 0, i % 8, i / 8, 250, 3, "R10");
        do_reset("R10");
        field(8, 8, 5, "R10");
        idle(2, "R10");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule